// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt events of a small multi-channel DMA controller into a single interrupt line. Each channel can report five kinds of event: the whole transfer is done, a block is done, a source-side handshake transaction is done, a destination-side handshake transaction is done, and a bus error. For every event kind the block keeps a sticky raw status word and a mask word, each with one bit per channel. The interrupt output is raised while any raw bit is set and its mask bit is also set.

Software reaches the status and mask words through a small register port. Writes take effect on the clock edge and reads are combinational. Writing to a raw status address clears the bits that are written as 1. The channel engines report events as one-cycle pulses. They also report, for each channel, whether its source side and its destination side are memory. Transaction events on a side that is memory are dropped. A bus error sets the error status bit and also sends a one-cycle disable request back to that channel, whatever the mask setting.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every raw status word, every mask word, `irq_o` and `ch_dis_o` are zero.
- R2: An event pulse on channel c sets bit c of that event's raw word at the clock edge where it is sampled. The bit then stays set until software clears it.
- R3: A source-transaction event is dropped for any channel whose `src_is_mem_i` bit is 1. A destination-transaction event is dropped for any channel whose `dst_is_mem_i` bit is 1.
- R4: The raw words are read at addresses 0 (transfer), 1 (block), 2 (source transaction), 3 (destination transaction) and 4 (error), with bit c belonging to channel c. Writing these addresses clears each bit written as 1. Bits written as 0 are unchanged.
- R5: If an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R6: The mask words sit at addresses 8 to 12, in the same order as the raw words. A write stores the low channel bits of the data, and a read returns them.
- R7: `irq_o` is 1 exactly when some raw bit and its matching mask bit are both 1. Nothing is forwarded while the masks are zero.
- R8: A rising error event on channel c drives `ch_dis_o[c]` high for exactly one cycle, in the cycle after the event is sampled. This happens whatever the error mask holds, and it stays one cycle long even if the error input is held high.
- R9: Address 5 reads a summary in which bit t is 1 when event kind t has any raw bit that is also unmasked. Any other unlisted address reads zero. Writes to address 5 or to any unlisted address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tfr_ev_i | input | NUM_CH | Transfer-done event pulses, one per channel |
| blk_ev_i | input | NUM_CH | Block-done event pulses |
| src_ev_i | input | NUM_CH | Source-side transaction-done event pulses |
| dst_ev_i | input | NUM_CH | Destination-side transaction-done event pulses |
| err_ev_i | input | NUM_CH | Bus error event pulses |
| src_is_mem_i | input | NUM_CH | Channel source side is memory |
| dst_is_mem_i | input | NUM_CH | Channel destination side is memory |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Aggregated interrupt |
| ch_dis_o | output | NUM_CH | Per-channel cancel-and-disable request |

## Verification
The assertions assume the event inputs are synchronous to `clk_i`. They also assume the memory flags are stable in the cycle an event is sampled, so the one-cycle check that dropped transaction events never show up is meaningful. The stimulus changes every input only at the falling edge. It holds events for a single cycle, except in one deliberate case where the error input is held high to exercise the disable edge detection. It changes the memory flags only while no transaction events are active.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_EV    = 5;
  localparam int EV_TFR    = 0;
  localparam int EV_BLK    = 1;
  localparam int EV_SRC    = 2;
  localparam int EV_DST    = 3;
  localparam int EV_ERR    = 4;
  localparam int RAW_BASE  = 0;
  localparam int SUM_ADDR  = 5;
  localparam int MASK_BASE = 8;
endpackage

// File: rtl/dma_irq_type_reg.sv
module dma_irq_type_reg #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic              mask_we_i,
  input  logic [NUM_CH-1:0] mask_wd_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] masked_o
);
  logic [NUM_CH-1:0] raw_q, mask_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wd_i;
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R5
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R2
endmodule

// File: rtl/dma_irq_err_ctl.sv
module dma_irq_err_ctl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] err_ev_i,
  output logic [NUM_CH-1:0] ch_dis_o
);
  logic [NUM_CH-1:0] err_q, dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      dis_q <= '0;
    end else begin
      err_q <= err_ev_i;
      dis_q <= err_ev_i & ~err_q;
    end
  end

  assign ch_dis_o = dis_q;

  AST_DIS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_dis_o != '0) |=> ((ch_dis_o & $past(ch_dis_o)) == '0)); // R8
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_EV-1:0][NUM_CH-1:0] raw_i,
  input  logic [NUM_EV-1:0][NUM_CH-1:0] mask_i,
  input  logic [NUM_EV-1:0]             type_hit_i,
  output logic [NUM_EV-1:0][NUM_CH-1:0] clr_o,
  output logic [NUM_EV-1:0]             mask_we_o,
  output logic [NUM_CH-1:0]             mask_wd_o,
  output logic [DATA_W-1:0]             rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CH];
  assign mask_wd_o    = wdata_i[NUM_CH-1:0];

  for (genvar t = 0; t < NUM_EV; t++) begin : g_dec
    localparam logic [ADDR_W-1:0] RAW_A  = ADDR_W'(RAW_BASE + t);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_BASE + t);
    assign clr_o[t]     = (wr_en_i && addr_i == RAW_A) ? wdata_i[NUM_CH-1:0] : '0;
    assign mask_we_o[t] = wr_en_i && addr_i == MASK_A;
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < NUM_EV; t++) begin
      if (addr_i == ADDR_W'(RAW_BASE + t))  rdata_o[NUM_CH-1:0] = raw_i[t];
      if (addr_i == ADDR_W'(MASK_BASE + t)) rdata_o[NUM_CH-1:0] = mask_i[t];
    end
    if (addr_i == ADDR_W'(SUM_ADDR)) rdata_o[NUM_EV-1:0] = type_hit_i;
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tfr_ev_i,
  input  logic [NUM_CH-1:0] blk_ev_i,
  input  logic [NUM_CH-1:0] src_ev_i,
  input  logic [NUM_CH-1:0] dst_ev_i,
  input  logic [NUM_CH-1:0] err_ev_i,
  input  logic [NUM_CH-1:0] src_is_mem_i,
  input  logic [NUM_CH-1:0] dst_is_mem_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] ch_dis_o
);
  logic [NUM_EV-1:0][NUM_CH-1:0] ev_set, clr, raw, mask, masked;
  logic [NUM_EV-1:0]             mask_we, type_hit;
  logic [NUM_CH-1:0]             mask_wd;

  // memory-side transaction events never reach status
  assign ev_set[EV_TFR] = tfr_ev_i;
  assign ev_set[EV_BLK] = blk_ev_i;
  assign ev_set[EV_SRC] = src_ev_i & ~src_is_mem_i;
  assign ev_set[EV_DST] = dst_ev_i & ~dst_is_mem_i;
  assign ev_set[EV_ERR] = err_ev_i;

  for (genvar t = 0; t < NUM_EV; t++) begin : g_type
    dma_irq_type_reg #(.NUM_CH(NUM_CH)) u_type (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (ev_set[t]),
      .clr_i     (clr[t]),
      .mask_we_i (mask_we[t]),
      .mask_wd_i (mask_wd),
      .raw_o     (raw[t]),
      .mask_o    (mask[t]),
      .masked_o  (masked[t])
    );
    assign type_hit[t] = |masked[t];
  end

  dma_irq_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .raw_i      (raw),
    .mask_i     (mask),
    .type_hit_i (type_hit),
    .clr_o      (clr),
    .mask_we_o  (mask_we),
    .mask_wd_o  (mask_wd),
    .rdata_o    (rdata_o)
  );

  dma_irq_err_ctl #(.NUM_CH(NUM_CH)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_ev_i (err_ev_i),
    .ch_dis_o (ch_dis_o)
  );

  assign irq_o = |type_hit;

  AST_NO_SRC_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_is_mem_i != '0) |=> ((raw[EV_SRC] & ~$past(raw[EV_SRC]) & $past(src_is_mem_i)) == '0)); // R3
  AST_NO_DST_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_is_mem_i != '0) |=> ((raw[EV_DST] & ~$past(raw[EV_DST]) & $past(dst_is_mem_i)) == '0)); // R3
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw & mask) != '0)); // R7
endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NE     = 5;

  logic clk = 0, rst_n = 0;
  logic [NUM_CH-1:0] tfr = '0, blk = '0, src = '0, dst = '0, err = '0;
  logic [NUM_CH-1:0] src_mem = '0, dst_mem = '0;
  logic wr_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;
  logic [NUM_CH-1:0] ch_dis;

  always #(CLK_P/2) clk = ~clk;

  dma_irq_agg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tfr_ev_i(tfr), .blk_ev_i(blk), .src_ev_i(src), .dst_ev_i(dst), .err_ev_i(err),
    .src_is_mem_i(src_mem), .dst_is_mem_i(dst_mem),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .ch_dis_o(ch_dis)
  );

  typedef struct {int sel; logic [DATA_W-1:0] val; string tag;} item_t;
  item_t q[$];
  event mon_ev;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [NUM_CH-1:0] m_raw [NE];
  logic [NUM_CH-1:0] m_mask[NE];

  // monitor: pops expected items and compares against the selected output
  always begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [DATA_W-1:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = rdata;
        1:       act = DATA_W'(irq);
        default: act = DATA_W'(ch_dis);
      endcase
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.val);
      end
    end
  end

  task automatic expect_out(input int sel, input logic [DATA_W-1:0] v, input string tag);
    item_t it;
    it.sel = sel; it.val = v; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #1;
  endtask

  function automatic logic [DATA_W-1:0] model_read(input int a);
    logic [DATA_W-1:0] r = '0;
    if (a < NE) r[NUM_CH-1:0] = m_raw[a];
    else if (a >= 8 && a < 8 + NE) r[NUM_CH-1:0] = m_mask[a-8];
    else if (a == 5) for (int t = 0; t < NE; t++) r[t] = |(m_raw[t] & m_mask[t]);
    return r;
  endfunction

  function automatic logic model_irq();
    logic x = 0;
    for (int t = 0; t < NE; t++) x |= |(m_raw[t] & m_mask[t]);
    return x;
  endfunction

  // one clock with events and optional write; ends just after the next falling edge
  task automatic step(input logic [NUM_CH-1:0] e_tfr, e_blk, e_src, e_dst, e_err,
                      input logic we, input int a, input logic [DATA_W-1:0] d,
                      input string tag);
    @(negedge clk);
    tfr = e_tfr; blk = e_blk; src = e_src; dst = e_dst; err = e_err;
    wr_en = we; addr = ADDR_W'(a); wdata = d;
    for (int t = 0; t < NE; t++) begin
      logic [NUM_CH-1:0] s, c;
      case (t)
        0: s = e_tfr;
        1: s = e_blk;
        2: s = e_src & ~src_mem;
        3: s = e_dst & ~dst_mem;
        default: s = e_err;
      endcase
      c = (we && a == t) ? d[NUM_CH-1:0] : '0;
      m_raw[t] = (m_raw[t] & ~c) | s;
      if (we && a == 8 + t) m_mask[t] = d[NUM_CH-1:0];
    end
    @(negedge clk);
    tfr = '0; blk = '0; src = '0; dst = '0; err = '0; wr_en = 0;
    #1;
    expect_out(2, DATA_W'(e_err), {tag, " ch_dis"});
    expect_out(1, DATA_W'(model_irq()), {tag, " irq"});
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1;
    expect_out(0, model_read(a), tag);
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d, input string tag);
    step('0, '0, '0, '0, '0, 1'b1, a, d, tag);
  endtask

  initial begin
    for (int t = 0; t < NE; t++) begin m_raw[t] = '0; m_mask[t] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 16; a++) rd(a, "R1 reset read");
    expect_out(1, '0, "R1 reset irq");
    expect_out(2, '0, "R1 reset ch_dis");

    // R2: events set sticky raw bits, masks still zero
    step(4'b0001, 4'b0100, '0, '0, '0, 0, 0, '0, "R2 tfr/blk event");
    step('0, '0, '0, '0, '0, 0, 0, '0, "R2 idle");
    rd(0, "R2 tfr raw sticky");
    rd(1, "R2 blk raw sticky");
    expect_out(1, '0, "R7 masked off irq");

    // R3: memory sides drop transaction events
    src_mem = 4'b0101; dst_mem = 4'b0011;
    step('0, '0, 4'b1111, 4'b1111, '0, 0, 0, '0, "R3 txn events");
    rd(2, "R3 src raw");
    rd(3, "R3 dst raw");
    src_mem = '0; dst_mem = '0;

    // R6/R7/R9: mask write, readback, irq, summary
    wr(8, 32'hFFFF_FFF1, "R6 mask tfr write");
    rd(8, "R6 mask tfr readback");
    expect_out(1, 1, "R7 irq on unmasked tfr");
    rd(5, "R9 summary tfr");
    wr(11, 32'h8, "R6 mask dst write");
    rd(5, "R9 summary tfr+dst");

    // R4: write-one-to-clear
    wr(0, 32'h0, "R4 zero write no clear");
    rd(0, "R4 tfr kept after zero write");
    wr(0, 32'h1, "R4 one write clears");
    rd(0, "R4 tfr cleared");
    wr(3, 32'h8, "R4 clear dst ch3");
    rd(3, "R4 dst partial clear");
    expect_out(1, 0, "R7 irq low after clears");

    // R5: event beats clear on the same bit
    step('0, 4'b0010, '0, '0, '0, 1, 1, 32'h6, "R5 set+clear same cycle");
    rd(1, "R5 blk raw event wins");

    // R8: error pulse independent of mask
    step('0, '0, '0, '0, 4'b1000, 0, 0, '0, "R8 err ch3");
    step('0, '0, '0, '0, '0, 0, 0, '0, "R8 err after");
    rd(4, "R8 err raw");
    // error held two cycles: single disable pulse
    @(negedge clk); err = 4'b0001; m_raw[4] |= 4'b0001;
    @(negedge clk); #1; expect_out(2, 32'h1, "R8 held err first cycle");
    @(negedge clk); err = '0; #1; expect_out(2, 32'h0, "R8 held err second cycle");
    wr(12, 32'h1, "R7 unmask err ch0");
    expect_out(1, 1, "R7 irq from err");

    // R9: unlisted addresses and summary address ignore writes
    wr(6, 32'hFFFF_FFFF, "R9 write addr6");
    wr(5, 32'hFFFF_FFFF, "R9 write addr5");
    wr(15, 32'hFFFF_FFFF, "R9 write addr15");
    rd(6, "R9 addr6 reads zero");
    rd(15, "R9 addr15 reads zero");
    for (int a = 0; a < NE; a++) rd(a, "R9 raw unchanged");
    for (int a = 8; a < 8 + NE; a++) rd(a, "R9 mask unchanged");
    rd(5, "R9 summary final");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule